// File: doc/BRIEF.md
# Request Packet Deserializer and Decoder

This block sits behind the request pins of a packetized memory channel. It has two lane groups, and they run independently. Three row lanes carry activate and row-operation commands. Five column lanes carry column commands, and each column command travels with a second, smaller sub-packet. That sub-packet is either a byte mask or an extended operation. The lane levels are low-true, so the block inverts every sample. It gathers eight bit times into one packet. It decodes the opcode, bank and address fields, and raises a single-cycle valid only when the packet's device address equals the programmed device ID.

The logic runs on one receive clock, and each cycle brings in two bit times per lane. Each lane input is therefore two samples wide, and the first bit time sits in the low half. A packet lasts four clock cycles. A framing input, high during the first of those cycles, starts assembly. Electrical signalling, clock recovery and the register port that would program the device ID are outside this block. The ID simply arrives as an input.

Top module: `req_pkt_rx`

## Requirements
- R1: While reset is low and in the first cycle after it, `row_vld`, `col_vld` and `col_xvld` are all 0.
- R2: Row packet bit number t*3+l carries lane l at bit time t, where t runs 0..7. In a cycle, input bits [2:0] of `row_lanes_n` hold bit time 2c and bits [5:3] hold bit time 2c+1, with c = 0..3 counted from the cycle in which `row_frame` is high. `row_vld` is high for exactly the one cycle after the fourth cycle.
- R3: Lane levels are low-true: every lane sample is inverted before it is placed in a packet.
- R4: Row packet layout: bit 0 = 1 for activate and 0 for row operation, bits 5:1 device, bits 9:6 bank, bits 18:10 row address (activate) and bits 12:10 row opcode (row operation). The outputs are `row_act`, `row_bank`, `row_addr` and `row_op`.
- R5: The column packet is 40 bits and is assembled like R2 with 5 lanes (bit t*5+l, `col_lanes_n` bits [4:0] first bit time). Bits 22:0 form the column command and bits 39:23 form the second sub-packet. `col_vld` lasts one cycle.
- R6: Column command layout: bit 0 mask-select M, bits 5:1 device, bits 9:6 bank, bits 15:10 column address, bits 19:16 column opcode. The outputs are `col_msk`, `col_bank`, `col_addr` and `col_op`.
- R7: With M=1, the second sub-packet is a byte mask. Its bits 15:0 appear on `col_mask` and `col_xvld` stays 0. With M=0, `col_mask` is 0.
- R8: With M=0, the second sub-packet is an extended operation: bits 4:0 device, bits 8:5 bank, bits 12:9 opcode, shown on `col_xbank` and `col_xop`. `col_xvld` pulses when that device field matches `dev_id`, whether or not the column command matched.
- R9: A row or column packet whose device field differs from `dev_id` raises no valid.
- R10: The row and column groups are independent, so `row_vld` and `col_vld` can be high in the same cycle, each with its own fields.
- R11: If a group's frame input is high while a packet is still being assembled, the partial packet is discarded and assembly restarts from bit time 0.
- R12: A frame in the cycle right after a packet's fourth cycle starts the next packet with no gap, and both packets are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dev_id | input | 5 | Programmed device ID |
| row_frame | input | 1 | High in the first cycle of a row packet |
| row_lanes_n | input | 6 | Row lanes, two bit times, low-true |
| col_frame | input | 1 | High in the first cycle of a column packet |
| col_lanes_n | input | 10 | Column lanes, two bit times, low-true |
| row_vld | output | 1 | Matching row packet decoded |
| row_act | output | 1 | 1 = activate, 0 = row operation |
| row_bank | output | 4 | Row command bank |
| row_addr | output | 9 | Row address to activate |
| row_op | output | 3 | Row operation opcode |
| col_vld | output | 1 | Matching column command decoded |
| col_op | output | 4 | Column opcode |
| col_bank | output | 4 | Column command bank |
| col_addr | output | 6 | Column address |
| col_msk | output | 1 | Second sub-packet is a byte mask |
| col_mask | output | 16 | Byte mask (0 when not a mask) |
| col_xvld | output | 1 | Matching extended operation decoded |
| col_xop | output | 4 | Extended opcode |
| col_xbank | output | 4 | Extended operation bank |

## Verification
Two pairs of events can fall in the same cycle. One pair is a row delivery and a column delivery, which the bench provokes by framing both groups together with different banks and opcodes. The other pair is a column command and its extended operation, each addressed separately. For the first pair, the bench checks that each valid pulses once and that its fields are not swapped with the other group's. For the second, it drives matching and mismatching device fields in both parts of one column packet and checks that each valid depends only on its own device field.

// File: rtl/req_pkt_pkg.sv
// Shared constants and decoded command types for the request packet receiver.
// Assumes two bit times per clock per lane and a fixed eight bit-time packet.
package req_pkt_pkg;
    localparam int DEV_W      = 5;
    localparam int BANK_W     = 4;
    localparam int ROW_ADDR_W = 9;
    localparam int ROP_W      = 3;
    localparam int COL_ADDR_W = 6;
    localparam int COP_W      = 4;
    localparam int XOP_W      = 4;
    localparam int MASK_W     = 16;

    localparam int ROW_LANES  = 3;
    localparam int COL_LANES  = 5;
    localparam int BEATS      = 4;   // clock cycles per packet
    localparam int ROW_PKT_W  = 2 * ROW_LANES * BEATS;
    localparam int COL_PKT_W  = 2 * COL_LANES * BEATS;
    localparam int COLC_W     = 23;
    localparam int COLX_W     = COL_PKT_W - COLC_W;

    // field positions shared by row and column commands
    localparam int KIND_POS   = 0;
    localparam int DEV_LSB    = 1;
    localparam int BANK_LSB   = DEV_LSB + DEV_W;
    localparam int ADDR_LSB   = BANK_LSB + BANK_W;
    localparam int COP_LSB    = ADDR_LSB + COL_ADDR_W;
    // extended sub-packet positions
    localparam int XBANK_LSB  = DEV_W;
    localparam int XOP_LSB    = XBANK_LSB + BANK_W;

    typedef struct packed {
        logic                  act;
        logic [BANK_W-1:0]     bank;
        logic [ROW_ADDR_W-1:0] addr;
        logic [ROP_W-1:0]      op;
    } row_cmd_t;

    typedef struct packed {
        logic                  msk;
        logic [BANK_W-1:0]     bank;
        logic [COL_ADDR_W-1:0] addr;
        logic [COP_W-1:0]      op;
        logic [MASK_W-1:0]     mask;
        logic [BANK_W-1:0]     xbank;
        logic [XOP_W-1:0]      xop;
    } col_cmd_t;
endpackage

// File: rtl/req_lane_deser.sv
// Gathers a group of low-true lanes into one wide packet over BEATS cycles.
// Assumes lanes_n carries two bit times per cycle, the earlier one in the low
// half. A frame restarts assembly at any time; pkt_vld pulses one cycle after
// the last beat is captured. Packet bit t*LANES+l holds lane l at bit time t.
module req_lane_deser #(
    parameter  int LANES = 3,
    parameter  int BEATS = 4,
    localparam int STEP  = 2 * LANES,
    localparam int PKT_W = STEP * BEATS,
    localparam int CNT_W = (BEATS > 2) ? $clog2(BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame,
    input  logic [STEP-1:0]  lanes_n,
    output logic [PKT_W-1:0] pkt,
    output logic             pkt_vld
);
    logic [PKT_W-1:0] shreg;
    logic [CNT_W-1:0] cnt;
    logic             busy;

    // Shift inverted samples in from the top so beat 0 ends at the low bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (frame || busy)
            shreg <= {~lanes_n, shreg[PKT_W-1:STEP]};
    end

    // Track the beat count and flag the packet once its last beat is in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            pkt_vld <= 1'b0;
        end else begin
            pkt_vld <= 1'b0;
            if (frame) begin
                busy <= 1'b1;
                cnt  <= CNT_W'(1);
            end else if (busy) begin
                if (cnt == CNT_W'(BEATS - 1)) begin
                    busy    <= 1'b0;
                    cnt     <= '0;
                    pkt_vld <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    assign pkt = shreg;
endmodule

// File: rtl/req_row_decode.sv
// Splits an assembled row packet into its command fields and qualifies it
// with a device-address match. Purely combinational.
module req_row_decode
    import req_pkt_pkg::*;
(
    input  logic [ROW_PKT_W-1:0] pkt,
    input  logic                 pkt_vld,
    input  logic [DEV_W-1:0]     dev_id,
    output row_cmd_t             cmd,
    output logic                 cmd_vld
);
    logic unused_row_rsvd;

    // Pull out the fields and compare the device address.
    always_comb begin
        cmd.act  = pkt[KIND_POS];
        cmd.bank = pkt[BANK_LSB +: BANK_W];
        cmd.addr = pkt[ADDR_LSB +: ROW_ADDR_W];
        cmd.op   = pkt[ADDR_LSB +: ROP_W];
        cmd_vld  = pkt_vld && (pkt[DEV_LSB +: DEV_W] == dev_id);
    end

    assign unused_row_rsvd = ^pkt[ROW_PKT_W-1:ADDR_LSB+ROW_ADDR_W];
endmodule

// File: rtl/req_col_decode.sv
// Splits an assembled column packet into the column command and its second
// sub-packet (byte mask or extended operation, picked by the M bit). The
// command and the extended operation each match their own device field.
module req_col_decode
    import req_pkt_pkg::*;
(
    input  logic [COL_PKT_W-1:0] pkt,
    input  logic                 pkt_vld,
    input  logic [DEV_W-1:0]     dev_id,
    output col_cmd_t             cmd,
    output logic                 cmd_vld,
    output logic                 xop_vld
);
    logic [COLC_W-1:0] colc;
    logic [COLX_W-1:0] colx;
    logic              unused_col_rsvd;

    assign colc = pkt[COLC_W-1:0];
    assign colx = pkt[COL_PKT_W-1:COLC_W];

    // Decode both sub-packets and qualify each valid.
    always_comb begin
        cmd.msk   = colc[KIND_POS];
        cmd.bank  = colc[BANK_LSB +: BANK_W];
        cmd.addr  = colc[ADDR_LSB +: COL_ADDR_W];
        cmd.op    = colc[COP_LSB +: COP_W];
        cmd.mask  = cmd.msk ? colx[MASK_W-1:0] : '0;
        cmd.xbank = colx[XBANK_LSB +: BANK_W];
        cmd.xop   = colx[XOP_LSB +: XOP_W];
        cmd_vld   = pkt_vld && (colc[DEV_LSB +: DEV_W] == dev_id);
        xop_vld   = pkt_vld && !cmd.msk && (colx[DEV_W-1:0] == dev_id);
    end

    assign unused_col_rsvd = ^{colc[COLC_W-1:COP_LSB+COP_W], colx[COLX_W-1:MASK_W]};
endmodule

// File: rtl/req_pkt_rx.sv
// Top of the request packet receiver: two independent 1:8 lane deserializers
// (row and column) feeding their decoders. Outputs are valid for one cycle.
module req_pkt_rx
    import req_pkt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DEV_W-1:0]      dev_id,
    input  logic                  row_frame,
    input  logic [2*ROW_LANES-1:0] row_lanes_n,
    input  logic                  col_frame,
    input  logic [2*COL_LANES-1:0] col_lanes_n,
    output logic                  row_vld,
    output logic                  row_act,
    output logic [BANK_W-1:0]     row_bank,
    output logic [ROW_ADDR_W-1:0] row_addr,
    output logic [ROP_W-1:0]      row_op,
    output logic                  col_vld,
    output logic [COP_W-1:0]      col_op,
    output logic [BANK_W-1:0]     col_bank,
    output logic [COL_ADDR_W-1:0] col_addr,
    output logic                  col_msk,
    output logic [MASK_W-1:0]     col_mask,
    output logic                  col_xvld,
    output logic [XOP_W-1:0]      col_xop,
    output logic [BANK_W-1:0]     col_xbank
);
    logic [ROW_PKT_W-1:0] row_pkt;
    logic [COL_PKT_W-1:0] col_pkt;
    logic                 row_pkt_vld, col_pkt_vld;
    row_cmd_t             row_cmd;
    col_cmd_t             col_cmd;

    req_lane_deser #(.LANES(ROW_LANES), .BEATS(BEATS)) u_row_deser (
        .clk(clk), .rst_n(rst_n), .frame(row_frame), .lanes_n(row_lanes_n),
        .pkt(row_pkt), .pkt_vld(row_pkt_vld)
    );

    req_lane_deser #(.LANES(COL_LANES), .BEATS(BEATS)) u_col_deser (
        .clk(clk), .rst_n(rst_n), .frame(col_frame), .lanes_n(col_lanes_n),
        .pkt(col_pkt), .pkt_vld(col_pkt_vld)
    );

    req_row_decode u_row_dec (
        .pkt(row_pkt), .pkt_vld(row_pkt_vld), .dev_id(dev_id),
        .cmd(row_cmd), .cmd_vld(row_vld)
    );

    req_col_decode u_col_dec (
        .pkt(col_pkt), .pkt_vld(col_pkt_vld), .dev_id(dev_id),
        .cmd(col_cmd), .cmd_vld(col_vld), .xop_vld(col_xvld)
    );

    // Flatten the decoded structs onto the port list.
    always_comb begin
        row_act   = row_cmd.act;
        row_bank  = row_cmd.bank;
        row_addr  = row_cmd.addr;
        row_op    = row_cmd.op;
        col_msk   = col_cmd.msk;
        col_bank  = col_cmd.bank;
        col_addr  = col_cmd.addr;
        col_op    = col_cmd.op;
        col_mask  = col_cmd.mask;
        col_xbank = col_cmd.xbank;
        col_xop   = col_cmd.xop;
    end
endmodule

// File: rtl/req_pkt_rx_chk.sv
// Assertion checker for req_pkt_rx, bound to every instance of it. Counts the
// cycles since each frame to check packet spacing without deep $past.
module req_pkt_rx_chk #(
    parameter int BEATS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic row_frame,
    input logic col_frame,
    input logic row_vld,
    input logic col_vld,
    input logic col_xvld,
    input logic col_msk
);
    localparam int SW = $clog2(BEATS + 2) + 1;
    localparam logic [SW-1:0] SAT = SW'(BEATS + 1);

    logic [SW-1:0] row_since, col_since;

    // Saturating count of cycles since the last row frame.
    always_ff @(posedge clk) begin
        if (!rst_n)             row_since <= SAT;
        else if (row_frame)     row_since <= SW'(1);
        else if (row_since != SAT) row_since <= row_since + SW'(1);
    end

    // Saturating count of cycles since the last column frame.
    always_ff @(posedge clk) begin
        if (!rst_n)             col_since <= SAT;
        else if (col_frame)     col_since <= SW'(1);
        else if (col_since != SAT) col_since <= col_since + SW'(1);
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) !rst_n |=> (!row_vld && !col_vld && !col_xvld)); // R1
    AST_ROW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) row_vld |=> !row_vld); // R2
    AST_COL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) col_vld |=> !col_vld); // R5
    AST_MASK_NO_XOP: assert property (@(posedge clk) disable iff (!rst_n) col_xvld |-> !col_msk); // R7
    AST_ROW_FRAME_SPACING: assert property (@(posedge clk) disable iff (!rst_n) row_vld |-> row_since == SW'(BEATS)); // R11
    AST_COL_FRAME_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (col_vld || col_xvld) |-> col_since == SW'(BEATS)); // R11
endmodule

bind req_pkt_rx req_pkt_rx_chk #(.BEATS(req_pkt_pkg::BEATS)) u_chk (
    .clk(clk), .rst_n(rst_n), .row_frame(row_frame), .col_frame(col_frame),
    .row_vld(row_vld), .col_vld(col_vld), .col_xvld(col_xvld), .col_msk(col_msk)
);

// File: tb/req_pkt_rx_test.sv
// Directed bench for req_pkt_rx: one task per scenario, each checking itself.
module req_pkt_rx_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  dev_id;
    logic        row_frame, col_frame;
    logic [5:0]  row_lanes_n;
    logic [9:0]  col_lanes_n;
    logic        row_vld, row_act, col_vld, col_msk, col_xvld;
    logic [3:0]  row_bank, col_op, col_bank, col_xop, col_xbank;
    logic [8:0]  row_addr;
    logic [2:0]  row_op;
    logic [5:0]  col_addr;
    logic [15:0] col_mask;

    int checks = 0, fails = 0;
    int rv_cnt = 0, cv_cnt = 0, xv_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    req_pkt_rx uut (.*);

    // Count valid pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            rv_cnt <= rv_cnt + int'(row_vld);
            cv_cnt <= cv_cnt + int'(col_vld);
            xv_cnt <= xv_cnt + int'(col_xvld);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] mk_act(input logic [4:0] d, input logic [3:0] b, input logic [8:0] r);
        return {5'b0, r, b, d, 1'b1};
    endfunction
    function automatic logic [23:0] mk_rop(input logic [4:0] d, input logic [3:0] b, input logic [2:0] o);
        return {11'b0, o, b, d, 1'b0};
    endfunction
    function automatic logic [39:0] mk_col(input logic m, input logic [4:0] d, input logic [3:0] b,
                                           input logic [5:0] c, input logic [3:0] o, input logic [16:0] s);
        return {s, 3'b0, o, c, b, d, m};
    endfunction
    function automatic logic [16:0] mk_x(input logic [4:0] d, input logic [3:0] b, input logic [3:0] o);
        return {4'b0, o, b, d};
    endfunction

    // Captured outputs of the last delivered packet.
    logic s_rv, s_ract, s_cv, s_cm, s_xv;
    logic [3:0] s_rbank, s_cop, s_cbank, s_xop, s_xbank;
    logic [8:0] s_raddr;
    logic [2:0] s_rop;
    logic [5:0] s_caddr;
    logic [15:0] s_mask;

    // Drive one packet per selected group over four cycles, starting and
    // ending at a falling edge; the ending edge samples the decoded outputs.
    task automatic send(input logic rs, input logic [23:0] rp, input logic cs, input logic [39:0] cp);
        for (int b = 0; b < 4; b++) begin
            row_frame   = rs && (b == 0);
            col_frame   = cs && (b == 0);
            row_lanes_n = rs ? ~rp[b*6 +: 6] : 6'h3f;
            col_lanes_n = cs ? ~cp[b*10 +: 10] : 10'h3ff;
            @(negedge clk);
        end
        s_rv = row_vld; s_ract = row_act; s_rbank = row_bank; s_raddr = row_addr; s_rop = row_op;
        s_cv = col_vld; s_cop = col_op; s_cbank = col_bank; s_caddr = col_addr; s_cm = col_msk;
        s_mask = col_mask; s_xv = col_xvld; s_xop = col_xop; s_xbank = col_xbank;
        row_frame = 0; col_frame = 0; row_lanes_n = 6'h3f; col_lanes_n = 10'h3ff;
    endtask

    task automatic t_reset;
        chk("R1 row_vld in reset", {31'b0, row_vld}, 0);
        chk("R1 col_vld in reset", {31'b0, col_vld}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valids after reset", {29'b0, row_vld, col_vld, col_xvld}, 0);
    endtask

    task automatic t_row_act;
        int r0 = rv_cnt;
        send(1, mk_act(5'h13, 4'hA, 9'h1C5), 0, '0);
        chk("R2 row_vld on 5th cycle", {31'b0, s_rv}, 1);
        chk("R4 row_act", {31'b0, s_ract}, 1);
        chk("R4 row_bank", {28'b0, s_rbank}, 32'hA);
        chk("R3 R4 row_addr inverted lanes", {23'b0, s_raddr}, 32'h1C5);
        @(negedge clk);
        chk("R2 row_vld one pulse", rv_cnt - r0, 1);
    endtask

    task automatic t_row_op;
        send(1, mk_rop(5'h13, 4'h3, 3'h6), 0, '0);
        chk("R4 row op valid", {31'b0, s_rv}, 1);
        chk("R4 row_act low", {31'b0, s_ract}, 0);
        chk("R4 row_op", {29'b0, s_rop}, 6);
        chk("R4 row op bank", {28'b0, s_rbank}, 3);
        @(negedge clk);
    endtask

    task automatic t_mismatch;
        int r0 = rv_cnt, c0 = cv_cnt;
        send(1, mk_act(5'h12, 4'h1, 9'h0FF), 1, mk_col(1, 5'h03, 4'h2, 6'h11, 4'h5, 17'h0F0F0));
        @(negedge clk);
        chk("R9 row mismatch no valid", rv_cnt - r0, 0);
        chk("R9 col mismatch no valid", cv_cnt - c0, 0);
    endtask

    task automatic t_col_mask;
        int x0 = xv_cnt;
        send(0, '0, 1, mk_col(1, 5'h13, 4'h7, 6'h2B, 4'h9, {1'b0, 16'hBEEF}));
        chk("R5 col_vld", {31'b0, s_cv}, 1);
        chk("R6 col_op", {28'b0, s_cop}, 9);
        chk("R6 col_bank", {28'b0, s_cbank}, 7);
        chk("R6 col_addr", {26'b0, s_caddr}, 32'h2B);
        chk("R7 col_msk", {31'b0, s_cm}, 1);
        chk("R7 col_mask", {16'b0, s_mask}, 32'hBEEF);
        @(negedge clk);
        chk("R7 no xop with mask", xv_cnt - x0, 0);
    endtask

    task automatic t_col_xop;
        int c0;
        send(0, '0, 1, mk_col(0, 5'h13, 4'h4, 6'h05, 4'h2, mk_x(5'h13, 4'hC, 4'hD)));
        chk("R8 xvld", {31'b0, s_xv}, 1);
        chk("R8 xop", {28'b0, s_xop}, 32'hD);
        chk("R8 xbank", {28'b0, s_xbank}, 32'hC);
        chk("R7 mask zero when M=0", {16'b0, s_mask}, 0);
        chk("R8 col_vld too", {31'b0, s_cv}, 1);
        @(negedge clk);
        // command for another device, extended op for this one
        c0 = cv_cnt;
        send(0, '0, 1, mk_col(0, 5'h04, 4'h4, 6'h05, 4'h2, mk_x(5'h13, 4'h8, 4'h1)));
        chk("R8 xvld independent of col match", {31'b0, s_xv}, 1);
        chk("R8 xop second", {28'b0, s_xop}, 1);
        @(negedge clk);
        chk("R9 col mismatch with xop", cv_cnt - c0, 0);
        // command for this device, extended op for another
        send(0, '0, 1, mk_col(0, 5'h13, 4'h4, 6'h05, 4'h2, mk_x(5'h07, 4'h8, 4'h1)));
        chk("R8 xvld needs own match", {30'b0, s_cv, s_xv}, 2);
        @(negedge clk);
    endtask

    task automatic t_both;
        send(1, mk_rop(5'h13, 4'h5, 3'h2), 1, mk_col(1, 5'h13, 4'hE, 6'h3F, 4'hF, {1'b0, 16'h8001}));
        chk("R10 both valid same cycle", {30'b0, s_rv, s_cv}, 3);
        chk("R10 row bank kept", {28'b0, s_rbank}, 5);
        chk("R10 col bank kept", {28'b0, s_cbank}, 32'hE);
        chk("R10 row op kept", {29'b0, s_rop}, 2);
        chk("R10 col addr kept", {26'b0, s_caddr}, 32'h3F);
        @(negedge clk);
    endtask

    task automatic t_restart;
        int r0 = rv_cnt, c0 = cv_cnt;
        // two beats of a partial packet, then a fresh frame
        for (int b = 0; b < 2; b++) begin
            row_frame = (b == 0); col_frame = (b == 0);
            row_lanes_n = 6'h00; col_lanes_n = 10'h000;
            @(negedge clk);
        end
        send(1, mk_act(5'h13, 4'h6, 9'h0A5), 1, mk_col(1, 5'h13, 4'h1, 6'h12, 4'h3, {1'b0, 16'h1234}));
        chk("R11 row restart fields", {19'b0, s_rv, s_rbank, s_raddr}, {19'b0, 1'b1, 4'h6, 9'h0A5});
        chk("R11 col restart fields", {16'b0, s_mask}, 32'h1234);
        @(negedge clk);
        chk("R11 one row pulse", rv_cnt - r0, 1);
        chk("R11 one col pulse", cv_cnt - c0, 1);
    endtask

    task automatic t_back2back;
        int r0 = rv_cnt, c0 = cv_cnt;
        send(1, mk_act(5'h13, 4'h2, 9'h111), 1, mk_col(1, 5'h13, 4'h2, 6'h01, 4'h1, 17'h0));
        chk("R12 first row", {23'b0, s_raddr}, 32'h111);
        send(1, mk_act(5'h13, 4'h9, 9'h0E2), 1, mk_col(1, 5'h13, 4'h9, 6'h02, 4'h4, 17'h0));
        chk("R12 second row", {23'b0, s_raddr}, 32'h0E2);
        chk("R12 second col", {26'b0, s_caddr}, 2);
        @(negedge clk);
        chk("R12 two row pulses", rv_cnt - r0, 2);
        chk("R12 two col pulses", cv_cnt - c0, 2);
    endtask

    initial begin
        rst_n = 1'b0; dev_id = 5'h13;
        row_frame = 0; col_frame = 0; row_lanes_n = 6'h3f; col_lanes_n = 10'h3ff;
        repeat (3) @(negedge clk);
        t_reset;
        t_row_act;
        t_row_op;
        t_mismatch;
        t_col_mask;
        t_col_xop;
        t_both;
        t_restart;
        t_back2back;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule